// File: doc/BRIEF.md
# Infrared pulse run-length sampler

This block sits behind a demodulated infrared receiver and turns its output into a stream of run-length symbols. The receiver output is synchronized and optionally inverted. It is then sampled once every `DIV` clocks; with the default of 64 and an 8 MHz clock, that is one sample every 8 µs. A noise filter removes short glitches. The surviving level is measured in runs of constant level.

Each finished run is pushed to a downstream FIFO as one byte. The push uses a single-cycle strobe with no back-pressure. The byte carries the level and the run length in samples, minus one. A run longer than 128 samples is split into full-length chunks. When the line has rested at the inactive level for long enough, the block flushes the last space chunk and marks the end of the packet. It then stays silent until the next active edge.

Software or a higher-level controller sets the thresholds and the polarity, then raises both enables. It reads the bytes from the FIFO and reacts to the packet-end pulse.

Top module: `ir_run_sampler`

## Requirements
- R1: While `glb_en` and `rx_en` are both high, the input is sampled once every `DIV` clocks, so a level held for N·DIV clocks counts as exactly N samples. Two pushes are never closer than `DIV` clocks apart.
- R2: Each symbol `sym_data` has the level in bit 7 (1 = pulse, 0 = space) and the run length in samples minus one in bits 6:0. A run is pushed when the filtered level changes.
- R3: With `invert` low, a high `ir_in` is a pulse. With `invert` high, a low `ir_in` is a pulse.
- R4: A level change lasting fewer than `noise_thr` consecutive samples is ignored, and its samples count toward the surrounding run. A change lasting `noise_thr` samples or more is kept. A `noise_thr` of 0 acts as 1.
- R5: When a run reaches 128 samples, a symbol with length field 127 (0xFF for a pulse, 0x7F for a space) is pushed, and counting restarts as a new run of the same level. A run of an exact multiple of 128 samples pushes nothing more at its end.
- R6: When a space reaches `idle_thr`·128 samples, its final 0x7F chunk is pushed in the same cycle as a one-cycle `pkt_end`. `pkt_end` never appears without a push. An `idle_thr` of 0 disables idle detection, and spaces then keep producing chunks.
- R7: After a packet end, no symbol is pushed while the line stays inactive. The first symbol afterwards is a pulse.
- R8: After reset, all outputs are low. While either enable is low, nothing is pushed. When the enables return, the run counter, the filter and the idle state start over as after reset, with the line taken to be at the space level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Synchronous active-low reset |
| glb_en | input | 1 | Global enable |
| rx_en | input | 1 | Receive enable |
| ir_in | input | 1 | Demodulated receiver output (asynchronous) |
| invert | input | 1 | Invert the input polarity |
| noise_thr | input | NTHR_W (6) | Glitch threshold in samples |
| idle_thr | input | IDLE_W (8) | Idle threshold in units of 128 samples |
| sym_data | output | 8 | Run symbol: level in bit 7, length minus one in bits 6:0 |
| sym_push | output | 1 | One-cycle push strobe for `sym_data` |
| pkt_end | output | 1 | One-cycle end-of-packet pulse |

## Verification
Two events can fall in the same cycle: the 128-sample chunk split of a space and the idle detection. At the idle point the final 0x7F chunk and `pkt_end` must appear together on one push. Each packet ends by holding the line inactive past `idle_thr`·128 samples, with `idle_thr` at 1, 2 and 0. The bench records `pkt_end` alongside every captured byte, so it can tell whether the flag sits on exactly the last chunk and on no earlier one. Any `pkt_end` seen without a push counts as a failure.

// File: rtl/ir_sampler_pkg.sv
// Shared symbol format of the infrared run-length sampler.
// Assumes the byte layout is fixed: level in the MSB, length-1 below it.
package ir_sampler_pkg;

    localparam int LEN_W = 7;

    typedef struct packed {
        logic             pulse;   // 1 = active level, 0 = space
        logic [LEN_W-1:0] len_m1;  // run length in samples minus one
    } run_sym_t;

endpackage

// File: rtl/ir_tick_div.sv
// Sample-tick divider: one-cycle tick every DIV clocks while enabled.
// Assumes DIV >= 1; the phase restarts whenever en is low.
module ir_tick_div #(
    parameter int DIV = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int            CW   = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] div_cnt;

    // Count clocks and issue a tick on the last one of each period.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            div_cnt <= '0;
            tick    <= 1'b0;
        end else begin
            tick    <= (div_cnt == LAST);
            div_cnt <= (div_cnt == LAST) ? '0 : div_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/ir_in_cond.sv
// Input conditioner: synchronizes the asynchronous receiver output and
// applies the polarity control. Assumes invert is quasi-static.
module ir_in_cond #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ir_raw,
    input  logic invert,
    output logic smp_lvl
);
    logic [SYNC_STAGES-1:0] sync_q;

    generate
        if (SYNC_STAGES > 1) begin : g_chain
            // Shift the raw input through the synchronizer chain.
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= {sync_q[SYNC_STAGES-2:0], ir_raw};
            end
        end else begin : g_single
            // Single capture flop when only one stage is requested.
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= ir_raw;
            end
        end
    endgenerate

    assign smp_lvl = sync_q[SYNC_STAGES-1] ^ invert;
endmodule

// File: rtl/ir_noise_filter.sv
// Glitch filter: the filtered level follows the sampled input only after
// the new level has been seen on noise_thr consecutive ticks (0 acts as 1).
// Every accepted change is delayed by the same amount, so run lengths of
// runs at least noise_thr long are preserved. Output valid one clock after tick.
module ir_noise_filter #(
    parameter int NTHR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              tick,
    input  logic              smp_lvl,
    input  logic [NTHR_W-1:0] noise_thr,
    output logic              flt_lvl,
    output logic              flt_vld
);
    logic [NTHR_W:0] cand_cnt;
    logic [NTHR_W:0] cand_inc;
    logic [NTHR_W:0] need;

    assign need     = (noise_thr == '0) ? (NTHR_W+1)'(1) : {1'b0, noise_thr};
    assign cand_inc = cand_cnt + 1'b1;

    // Track how long the sampled level has differed and accept it at threshold.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            flt_lvl  <= 1'b0;
            cand_cnt <= '0;
            flt_vld  <= 1'b0;
        end else begin
            flt_vld <= tick;
            if (tick) begin
                if (smp_lvl == flt_lvl) begin
                    cand_cnt <= '0;
                end else if (cand_inc >= need) begin
                    flt_lvl  <= smp_lvl;
                    cand_cnt <= '0;
                end else begin
                    cand_cnt <= cand_inc;
                end
            end
        end
    end
endmodule

// File: rtl/ir_run_encoder.sv
// Run encoder: counts filtered samples of constant level, pushes a symbol
// when the level changes or a run reaches 2**LEN_W samples, and detects an
// idle line after idle_thr full space chunks. Assumes one flt_vld per sample.
module ir_run_encoder
    import ir_sampler_pkg::*;
#(
    parameter int IDLE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              flt_vld,
    input  logic              flt_lvl,
    input  logic [IDLE_W-1:0] idle_thr,
    output run_sym_t          sym_q,
    output logic              push_q,
    output logic              pend_q
);
    localparam logic [LEN_W-1:0] CNT_MAX = '1;

    logic              cur_lvl, cur_lvl_n;
    logic [LEN_W-1:0]  run_cnt, run_cnt_n;
    logic [IDLE_W-1:0] chunks, chunks_n;
    logic              idle, idle_n;
    logic              emit, pend;
    run_sym_t          sym_n;
    logic [IDLE_W:0]   chunk_inc;

    assign chunk_inc = {1'b0, chunks} + 1'b1;

    // Decide the next run state and whether a symbol leaves this sample.
    always_comb begin
        cur_lvl_n = cur_lvl;
        run_cnt_n = run_cnt;
        chunks_n  = chunks;
        idle_n    = idle;
        emit      = 1'b0;
        pend      = 1'b0;
        sym_n     = '0;
        if (flt_vld) begin
            if (idle) begin
                if (flt_lvl) begin
                    idle_n    = 1'b0;
                    cur_lvl_n = 1'b1;
                    run_cnt_n = LEN_W'(1);
                    chunks_n  = '0;
                end
            end else if (flt_lvl != cur_lvl) begin
                if (run_cnt != '0) begin
                    emit         = 1'b1;
                    sym_n.pulse  = cur_lvl;
                    sym_n.len_m1 = run_cnt - 1'b1;
                end
                cur_lvl_n = flt_lvl;
                run_cnt_n = LEN_W'(1);
                chunks_n  = '0;
            end else if (run_cnt == CNT_MAX) begin
                emit         = 1'b1;
                sym_n.pulse  = cur_lvl;
                sym_n.len_m1 = CNT_MAX;
                run_cnt_n    = '0;
                if (!cur_lvl) begin
                    chunks_n = chunk_inc[IDLE_W-1:0];
                    if (idle_thr != '0 && chunk_inc == {1'b0, idle_thr}) begin
                        pend     = 1'b1;
                        idle_n   = 1'b1;
                        chunks_n = '0;
                    end
                end
            end else begin
                run_cnt_n = run_cnt + 1'b1;
            end
        end
    end

    // Register the run state and the outgoing symbol, strobe and packet end.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cur_lvl <= 1'b0;
            run_cnt <= '0;
            chunks  <= '0;
            idle    <= 1'b0;
            sym_q   <= '0;
            push_q  <= 1'b0;
            pend_q  <= 1'b0;
        end else begin
            cur_lvl <= cur_lvl_n;
            run_cnt <= run_cnt_n;
            chunks  <= chunks_n;
            idle    <= idle_n;
            push_q  <= emit;
            pend_q  <= pend;
            if (emit) sym_q <= sym_n;
        end
    end
endmodule

// File: rtl/ir_run_sampler.sv
// Infrared pulse run-length sampler top: conditioner, tick divider, glitch
// filter and run encoder in a chain. Both enables must be high to run;
// dropping either clears all run state. Outputs are registered.
module ir_run_sampler
    import ir_sampler_pkg::*;
#(
    parameter int DIV         = 64,
    parameter int SYNC_STAGES = 2,
    parameter int NTHR_W      = 6,
    parameter int IDLE_W      = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              glb_en,
    input  logic              rx_en,
    input  logic              ir_in,
    input  logic              invert,
    input  logic [NTHR_W-1:0] noise_thr,
    input  logic [IDLE_W-1:0] idle_thr,
    output logic [7:0]        sym_data,
    output logic              sym_push,
    output logic              pkt_end
);
    logic     run_en;
    logic     smp_lvl;
    logic     tick;
    logic     flt_lvl;
    logic     flt_vld;
    run_sym_t sym;

    assign run_en = glb_en & rx_en;

    ir_in_cond #(.SYNC_STAGES(SYNC_STAGES)) u_cond (
        .clk     (clk),
        .rst_n   (rst_n),
        .ir_raw  (ir_in),
        .invert  (invert),
        .smp_lvl (smp_lvl)
    );

    ir_tick_div #(.DIV(DIV)) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (run_en),
        .tick  (tick)
    );

    ir_noise_filter #(.NTHR_W(NTHR_W)) u_flt (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (run_en),
        .tick      (tick),
        .smp_lvl   (smp_lvl),
        .noise_thr (noise_thr),
        .flt_lvl   (flt_lvl),
        .flt_vld   (flt_vld)
    );

    ir_run_encoder #(.IDLE_W(IDLE_W)) u_enc (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (run_en),
        .flt_vld  (flt_vld),
        .flt_lvl  (flt_lvl),
        .idle_thr (idle_thr),
        .sym_q    (sym),
        .push_q   (sym_push),
        .pend_q   (pkt_end)
    );

    assign sym_data = sym;
endmodule

// File: rtl/ir_run_sampler_chk.sv
// Protocol checker for the run-length sampler outputs, bound to the top.
module ir_run_sampler_chk #(
    parameter int DIV = 64
) (
    input logic       clk,
    input logic       rst_n,
    input logic       glb_en,
    input logic       rx_en,
    input logic [7:0] sym_data,
    input logic       sym_push,
    input logic       pkt_end
);
    logic after_idle;

    // Remember that a packet has ended until the next push or disable.
    always_ff @(posedge clk) begin
        if (!rst_n || !(glb_en && rx_en)) after_idle <= 1'b0;
        else if (pkt_end)                 after_idle <= 1'b1;
        else if (sym_push)                after_idle <= 1'b0;
    end

    p_quiet_when_disabled_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(glb_en && rx_en) |=> (!sym_push && !pkt_end));

    p_pkt_end_on_chunk_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_end |-> (sym_push && sym_data == 8'h7F));

    p_pkt_end_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_end |=> !pkt_end);

    p_pulse_after_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (after_idle && sym_push) |-> sym_data[7]);

    p_push_spacing_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (DIV > 1 && sym_push) |=> !sym_push);
endmodule

bind ir_run_sampler ir_run_sampler_chk #(.DIV(DIV)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .glb_en   (glb_en),
    .rx_en    (rx_en),
    .sym_data (sym_data),
    .sym_push (sym_push),
    .pkt_end  (pkt_end)
);

// File: tb/ir_run_sampler_test.sv
module ir_run_sampler_test;
    localparam int CLK_PERIOD = 10;
    localparam int DIV        = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       glb_en = 1'b0;
    logic       rx_en = 1'b0;
    logic       ir_in = 1'b0;
    logic       invert = 1'b0;
    logic [5:0] noise_thr = 6'd3;
    logic [7:0] idle_thr = 8'd1;
    logic [7:0] sym_data;
    logic       sym_push;
    logic       pkt_end;

    int n_checks = 0;
    int n_errors = 0;
    logic inv_drv = 1'b0;
    logic [8:0] got_q[$];
    logic [8:0] exp_q[$];
    int cyc = 0;
    int last_push = -1000;

    ir_run_sampler #(.DIV(DIV)) uut (
        .clk(clk), .rst_n(rst_n), .glb_en(glb_en), .rx_en(rx_en),
        .ir_in(ir_in), .invert(invert), .noise_thr(noise_thr),
        .idle_thr(idle_thr), .sym_data(sym_data), .sym_push(sym_push),
        .pkt_end(pkt_end)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Capture pushes away from the active edge and police spacing and pkt_end.
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (sym_push) begin
                got_q.push_back({pkt_end, sym_data});
                n_checks++;
                if (cyc - last_push < DIV) begin
                    n_errors++;
                    $display("FAIL R1 push gap: got %0d expected >= %0d", cyc - last_push, DIV);
                end
                last_push = cyc;
            end else if (pkt_end) begin
                n_errors++;
                $display("FAIL R6 pkt_end without push: got push=0 expected 1");
            end
        end
    end

    task automatic run_lvl(input logic lvl, input int n);
        ir_in = lvl ^ inv_drv;
        repeat (n * DIV) @(negedge clk);
    endtask

    task automatic exp_run(input logic lvl, input int n);
        int r = n;
        while (r >= 128) begin
            exp_q.push_back({1'b0, lvl, 7'd127});
            r -= 128;
        end
        if (r > 0) exp_q.push_back({1'b0, lvl, 7'(r - 1)});
    endtask

    task automatic exp_idle(input int k);
        for (int i = 0; i < k; i++) exp_q.push_back({(i == k - 1), 8'h7F});
    endtask

    // Hold the space level until idle and expect the final chunks.
    task automatic go_idle(input int k);
        run_lvl(1'b0, 128 * k + 8);
        exp_idle(k);
    endtask

    task automatic compare(input string tag);
        n_checks++;
        if (got_q.size() != exp_q.size()) begin
            n_errors++;
            $display("FAIL %s symbol count: got %0d expected %0d", tag, got_q.size(), exp_q.size());
        end
        for (int i = 0; i < got_q.size() && i < exp_q.size(); i++) begin
            n_checks++;
            if (got_q[i] !== exp_q[i]) begin
                n_errors++;
                $display("FAIL %s symbol %0d: got pend=%0b byte=%02h expected pend=%0b byte=%02h",
                         tag, i, got_q[i][8], got_q[i][7:0], exp_q[i][8], exp_q[i][7:0]);
            end
        end
        got_q.delete();
        exp_q.delete();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        // R8: reset state of the outputs
        n_checks++;
        if (sym_push !== 1'b0 || pkt_end !== 1'b0 || sym_data !== 8'h00) begin
            n_errors++;
            $display("FAIL R8 reset outputs: got %0b %0b %02h expected 0 0 00", sym_push, pkt_end, sym_data);
        end
        rst_n = 1'b1;
        @(negedge clk);

        // R8 / R1: only one enable high -> nothing pushed
        glb_en = 1'b1;
        for (int i = 0; i < 6; i++) run_lvl(i[0], 40);
        glb_en = 1'b0; rx_en = 1'b1;
        for (int i = 0; i < 6; i++) run_lvl(i[0], 40);
        run_lvl(1'b0, 2);
        compare("R8 disabled");

        // R6: fresh enable with the line at space ends in one flushed chunk
        glb_en = 1'b1;
        go_idle(1);
        compare("R6 first idle");

        // R2 / R1: basic packet
        run_lvl(1, 9);  exp_run(1, 9);
        run_lvl(0, 4);  exp_run(0, 4);
        run_lvl(1, 3);  exp_run(1, 3);
        run_lvl(0, 17); exp_run(0, 17);
        run_lvl(1, 40); exp_run(1, 40);
        go_idle(1);
        compare("R2 basic");

        // R5 / R2: sweep of pulse lengths across the 128 split
        for (int len = 3; len <= 135; len++) begin
            run_lvl(1, len); exp_run(1, len);
            run_lvl(0, 3 + len % 11); exp_run(0, 3 + len % 11);
        end
        run_lvl(1, 256); exp_run(1, 256);
        go_idle(1);
        compare("R5 sweep");

        // R4: glitches below threshold merge, at threshold they survive
        run_lvl(1, 10); run_lvl(0, 2); run_lvl(1, 10); exp_run(1, 22);
        run_lvl(0, 10); run_lvl(1, 2); run_lvl(0, 1); run_lvl(1, 1); run_lvl(0, 10); exp_run(0, 24);
        run_lvl(1, 6);  exp_run(1, 6);
        run_lvl(0, 3);  exp_run(0, 3);
        run_lvl(1, 6);  exp_run(1, 6);
        go_idle(1);
        compare("R4 threshold 3");

        // R4: threshold 0 acts as 1, single-sample runs survive
        noise_thr = 6'd0;
        run_lvl(1, 1); exp_run(1, 1);
        run_lvl(0, 1); exp_run(0, 1);
        run_lvl(1, 2); exp_run(1, 2);
        run_lvl(0, 1); exp_run(0, 1);
        run_lvl(1, 1); exp_run(1, 1);
        go_idle(1);
        compare("R4 threshold 0");
        noise_thr = 6'd3;

        // R3 / R5: inverted polarity, low input is a pulse
        inv_drv = 1'b1; invert = 1'b1; ir_in = 1'b1;
        run_lvl(0, 20);
        run_lvl(1, 12);  exp_run(1, 12);
        run_lvl(0, 5);   exp_run(0, 5);
        run_lvl(1, 130); exp_run(1, 130);
        go_idle(1);
        compare("R3 invert");

        // R6: idle threshold 2 flags only the second chunk
        idle_thr = 8'd2;
        run_lvl(1, 5); exp_run(1, 5);
        go_idle(2);
        run_lvl(0, 50);
        compare("R6 idle 2");

        // R6: idle threshold 0 never ends the packet
        idle_thr = 8'd0;
        run_lvl(1, 5);   exp_run(1, 5);
        run_lvl(0, 300); exp_run(0, 300);
        run_lvl(1, 4);   exp_run(1, 4);
        idle_thr = 8'd1;
        go_idle(1);
        compare("R6 idle 0");

        // R7: long quiet line after idle, then a pulse comes first
        run_lvl(0, 300);
        run_lvl(1, 7); exp_run(1, 7);
        go_idle(1);
        compare("R7 after idle");

        // R8: disable mid-pulse clears the run, restart behaves like reset
        run_lvl(1, 50);
        rx_en = 1'b0;
        run_lvl(0, 5);
        rx_en = 1'b1;
        go_idle(1);
        compare("R8 re-enable");

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule